// File: doc/BRIEF.md
# Seven-Pin GPIO Port Register Bank

This block runs seven general-purpose pins from a small register file on a plain synchronous bus. Each pin has its own direction, polarity and output-style setting. A pin set as an input is tri-stated, and its level crosses a two-flop synchronizer before software can read it. A pin set as an output drives a flip-flop value, optionally inverted. In pulse style, writing a one to that flip-flop starts a timed active pulse, and the bit clears itself when the pulse ends.

While reset is held, and only if the external capture enable is high, a separate latch records the raw pin levels. After reset, software can read the recorded value, and its three low bits are presented as a strapped bus address. The host bus that reaches these registers and the pad cells are outside this block.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, the output data register reads 0x00, polarity reads 0x70, direction reads 0x7F and output style reads 0x00. Every pin output enable is low.
- R2: Read data appears on `bus_rdata` in the cycle after the edge that sampled `bus_rd`. When no read was sampled, `bus_rdata` is 0x00. A read of any address outside 0x08–0x0D returns 0x00.
- R3: Bit 7 of every register reads 0. Writes to 0x08 (input data), 0x0D (strap latch) and 0x0E–0x0F change no register.
- R4: Direction register 0x0B: a bit of 1 makes a pin an input and a bit of 0 makes it an output. `pad_oe[i]` is high exactly when direction bit i is 0.
- R5: Input data register 0x08: for an input pin, bit i reads the synchronized pin level XOR polarity bit i. For an output pin, bit i reads 0.
- R6: A change on `pad_in` reaches register 0x08 through two flops. A read sampled at the first or second edge after the change returns the old value, and a read sampled at the third edge returns the new value.
- R7: Polarity register 0x0A: in level style (style bit 0), `pad_out[i]` equals output data bit i XOR polarity bit i.
- R8: A read of output data register 0x09 returns the stored flip-flop bits, not the pin levels.
- R9: Output style register 0x0C, bit 1 = pulse. Writing 1 to data bit i of a pulse-style pin drives the active level on `pad_out[i]` for PULSE_CLKS cycles (default 4). The pin then returns to the inactive level, and data bit i reads 0.
- R10: Writing 1 again to a pulse-style pin during its pulse restarts the full PULSE_CLKS count. Writing 0 ends the pulse at once.
- R11: While `rst` is high and `strap_capture_en` is high, the latch at 0x0D samples raw `pad_in` on every clock. `strap_addr` is latch bits 2..0.
- R12: The strap latch holds its value whenever `rst` is low. It also holds through a reset during which `strap_capture_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 7 | Pin levels from pads |
| pad_out | output | 7 | Pin drive values |
| pad_oe | output | 7 | Per-pin output enables |
| strap_capture_en | input | 1 | Allows the strap latch to sample during reset |
| strap_addr | output | 3 | Strapped address from latch bits 2..0 |

## Verification
The hardest case to reach is a pulse that is restarted partway through. To get there, the stimulus makes a pin an output, puts it in pulse style, writes a one, waits two cycles and writes a one again. The pin must then stay active for a full new count rather than dropping on the first schedule, so the bench samples the pin on every cycle across the point where the first pulse would have ended. The strap latch's hold behaviour also needs a second reset, run with the capture enable low and different pin levels applied, followed by a read of the latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PORT_PINS = 7;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int STRAP_W   = 3;

    localparam logic [ADDR_W-1:0] OFS_IN    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h09;
    localparam logic [ADDR_W-1:0] OFS_POL   = 8'h0A;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h0B;
    localparam logic [ADDR_W-1:0] OFS_STYLE = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STRAP = 8'h0D;

    localparam logic [PORT_PINS-1:0] POL_RST   = 7'h70;
    localparam logic [PORT_PINS-1:0] DIR_RST   = 7'h7F;
    localparam logic [PORT_PINS-1:0] STYLE_RST = 7'h00;

    typedef logic [PORT_PINS-1:0] pin_vec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN,
        SEL_OUT,
        SEL_POL,
        SEL_DIR,
        SEL_STYLE,
        SEL_STRAP
    } reg_sel_e;

    typedef struct packed {
        pin_vec_t invert;
        pin_vec_t is_input;
        pin_vec_t pulse_mode;
    } port_cfg_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_IN:    return SEL_IN;
            OFS_OUT:   return SEL_OUT;
            OFS_POL:   return SEL_POL;
            OFS_DIR:   return SEL_DIR;
            OFS_STYLE: return SEL_STYLE;
            OFS_STRAP: return SEL_STRAP;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] widen(input pin_vec_t v);
        return {{(REG_W-PORT_PINS){1'b0}}, v};
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_strap_latch.sv
module gpio_strap_latch #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_en,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] latched
);
    // Sampled only while reset is active; no reset term by design.
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst && capture_en) begin
            hold_q <= pins;
        end
    end

    assign latched = hold_q;
endmodule

// File: rtl/gpio_out_bit.sv
module gpio_out_bit #(
    parameter int PULSE_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_strobe,
    input  logic wr_bit,
    input  logic pulse_mode,
    output logic data_q
);
    localparam int CNT_W = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
            cnt_q <= LOAD;
        end else if (wr_strobe) begin
            bit_q <= wr_bit;
            cnt_q <= LOAD;
        end else if (!pulse_mode) begin
            cnt_q <= LOAD;
        end else if (bit_q) begin
            if (cnt_q == '0) begin
                bit_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign data_q = bit_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr,
    input  logic              rd,
    input  pin_vec_t          in_view,
    input  pin_vec_t          out_view,
    input  pin_vec_t          strap_view,
    output port_cfg_t         cfg,
    output logic              out_wr,
    output logic [REG_W-1:0]  rdata
);
    reg_sel_e  sel;
    port_cfg_t cfg_q;
    pin_vec_t  wbits;
    logic      unused_wbits;

    assign sel          = decode_sel(addr);
    assign wbits        = wdata[PORT_PINS-1:0];
    assign unused_wbits = ^wdata[REG_W-1:PORT_PINS];
    assign out_wr       = wr && (sel == SEL_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.invert     <= POL_RST;
            cfg_q.is_input   <= DIR_RST;
            cfg_q.pulse_mode <= STYLE_RST;
        end else if (wr) begin
            case (sel)
                SEL_POL:   cfg_q.invert     <= wbits;
                SEL_DIR:   cfg_q.is_input   <= wbits;
                SEL_STYLE: cfg_q.pulse_mode <= wbits;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel)
                SEL_IN:    rdata <= widen(in_view);
                SEL_OUT:   rdata <= widen(out_view);
                SEL_POL:   rdata <= widen(cfg_q.invert);
                SEL_DIR:   rdata <= widen(cfg_q.is_input);
                SEL_STYLE: rdata <= widen(cfg_q.pulse_mode);
                SEL_STRAP: rdata <= widen(strap_view);
                default:   rdata <= '0;
            endcase
        end else begin
            rdata <= '0;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int PULSE_CLKS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [PORT_PINS-1:0] pad_in,
    output logic [PORT_PINS-1:0] pad_out,
    output logic [PORT_PINS-1:0] pad_oe,
    input  logic                 strap_capture_en,
    output logic [STRAP_W-1:0]   strap_addr
);
    pin_vec_t  pins_sync;
    pin_vec_t  strap_bits;
    pin_vec_t  out_q;
    pin_vec_t  in_view;
    pin_vec_t  pulse_mode_v;
    port_cfg_t cfg;
    logic      out_wr;

    gpio_in_sync #(.WIDTH(PORT_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    gpio_strap_latch #(.WIDTH(PORT_PINS)) strap_i (
        .clk        (clk),
        .rst        (rst),
        .capture_en (strap_capture_en),
        .pins       (pad_in),
        .latched    (strap_bits)
    );

    assign in_view = (pins_sync ^ cfg.invert) & cfg.is_input;

    gpio_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .in_view    (in_view),
        .out_view   (out_q),
        .strap_view (strap_bits),
        .cfg        (cfg),
        .out_wr     (out_wr),
        .rdata      (bus_rdata)
    );

    for (genvar g = 0; g < PORT_PINS; g++) begin : g_pin
        gpio_out_bit #(.PULSE_CLKS(PULSE_CLKS)) bit_i (
            .clk        (clk),
            .rst        (rst),
            .wr_strobe  (out_wr),
            .wr_bit     (bus_wdata[g]),
            .pulse_mode (cfg.pulse_mode[g]),
            .data_q     (out_q[g])
        );
    end

    assign pulse_mode_v = cfg.pulse_mode;
    assign pad_out      = out_q ^ cfg.invert;
    assign pad_oe       = ~cfg.is_input;
    assign strap_addr   = strap_bits[STRAP_W-1:0];
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int PULSE_CLKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [REG_W-1:0]     bus_rdata,
    input logic [PORT_PINS-1:0] pad_oe,
    input logic [STRAP_W-1:0]   strap_addr,
    input logic [PORT_PINS-1:0] out_q,
    input logic [PORT_PINS-1:0] pulse_mode
);
    // R2: no read sampled means zero read data next cycle
    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    // R3: reserved bit never set
    assert_bit7_zero_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (bus_rdata[REG_W-1] == 1'b0));

    // R4: enables only move after a write
    assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pad_oe));

    // R12: strap address frozen outside reset
    assert_strap_hold_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_addr));

    for (genvar g = 0; g < PORT_PINS; g++) begin : g_run
        logic [15:0] run_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                run_q <= '0;
            end else if (bus_wr && bus_addr == OFS_OUT) begin
                run_q <= '0;
            end else if (pulse_mode[g] && out_q[g]) begin
                if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
            end else begin
                run_q <= '0;
            end
        end

        // R9: a pulse never outlasts its length
        assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst)
            (pulse_mode[g] && out_q[g]) |-> (run_q < 16'(PULSE_CLKS)));
    end
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.PULSE_CLKS(PULSE_CLKS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .strap_addr (strap_addr),
    .out_q      (out_q),
    .pulse_mode (pulse_mode_v)
);

// File: tb/gpio_port_bank_tb_top.sv
module gpio_port_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [6:0] pad_in = 7'h55;
    logic [6:0] pad_out;
    logic [6:0] pad_oe;
    logic       strap_capture_en = 1'b1;
    logic [2:0] strap_addr;

    int total = 0;
    int fails = 0;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpio_port_bank dut_i (
        .clk              (clk),
        .rst              (rst),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_wr           (bus_wr),
        .bus_rd           (bus_rd),
        .bus_rdata        (bus_rdata),
        .pad_in           (pad_in),
        .pad_out          (pad_out),
        .pad_oe           (pad_oe),
        .strap_capture_en (strap_capture_en),
        .strap_addr       (strap_addr)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item for every read the design sampled
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 8'hEE, 8'h00);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, bus_rdata, e.val);
            end
        end
    end

    // Tasks are entered at a falling edge and leave at the next one
    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.tag = tag; e.val = exp;
        exp_q.push_back(e);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // first reset with capture enabled, pins 0x55
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        bus_read(8'h09, 8'h00, "R1 out reset");
        bus_read(8'h0A, 8'h70, "R1 pol reset");
        bus_read(8'h0B, 8'h7F, "R1 dir reset");
        bus_read(8'h0C, 8'h00, "R1 style reset");
        check("R1 oe reset", {1'b0, pad_oe}, 8'h00);

        // R11 strap capture
        bus_read(8'h0D, 8'h55, "R11 strap latch");
        check("R11 strap addr", {5'b0, strap_addr}, 8'h05);

        // R5 input with polarity
        pad_in = 7'h53;
        idle(3);
        bus_read(8'h08, 8'h23, "R5 input inverted");

        // R6 synchronizer latency
        pad_in = 7'h0C;
        bus_read(8'h08, 8'h23, "R6 first edge old");
        bus_read(8'h08, 8'h23, "R6 second edge old");
        bus_read(8'h08, 8'h7C, "R6 third edge new");

        // R2 unmapped and idle
        bus_read(8'h03, 8'h00, "R2 unmapped low");
        bus_read(8'h10, 8'h00, "R2 unmapped high");
        idle(1);
        check("R2 idle rdata", bus_rdata, 8'h00);

        // R3 reserved bit and ignored writes
        bus_write(8'h0A, 8'hFF);
        bus_read(8'h0A, 8'h7F, "R3 bit7 reads zero");
        bus_write(8'h0A, 8'h70);
        bus_write(8'h08, 8'hFF);
        bus_write(8'h0D, 8'h00);
        bus_write(8'h0E, 8'hFF);
        bus_write(8'h0F, 8'h00);
        bus_read(8'h08, 8'h7C, "R3 input unchanged");
        bus_read(8'h0D, 8'h55, "R3 strap unchanged");
        bus_read(8'h0E, 8'h00, "R3 reserved reads zero");
        bus_read(8'h0B, 8'h7F, "R3 dir unchanged");
        bus_read(8'h09, 8'h00, "R3 out unchanged");

        // R4 direction and enables
        bus_write(8'h0B, 8'h6E);
        check("R4 oe pins 0 and 4", {1'b0, pad_oe}, 8'h11);
        bus_read(8'h08, 8'h6C, "R5 output pins read zero");

        // R7 level output with polarity
        check("R7 level out zero", {1'b0, pad_out & 7'h11}, 8'h10);
        bus_write(8'h09, 8'h10);
        check("R7 level out one", {1'b0, pad_out & 7'h11}, 8'h00);
        bus_read(8'h09, 8'h10, "R8 out readback is flop");

        // R9 pulse on pin 0
        bus_write(8'h0C, 8'h01);
        bus_write(8'h09, 8'h11);
        check("R9 pulse c1", {7'b0, pad_out[0]}, 8'h01);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            check("R9 pulse active", {7'b0, pad_out[0]}, 8'h01);
        end
        @(negedge clk);
        check("R9 pulse ended", {7'b0, pad_out[0]}, 8'h00);
        check("R9 level pin kept", {7'b0, pad_out[4]}, 8'h00);
        bus_read(8'h09, 8'h10, "R9 data self cleared");

        // R10 retrigger
        bus_write(8'h09, 8'h11);
        check("R10 first c1", {7'b0, pad_out[0]}, 8'h01);
        @(negedge clk);
        check("R10 first c2", {7'b0, pad_out[0]}, 8'h01);
        bus_write(8'h09, 8'h11);
        check("R10 restart c1", {7'b0, pad_out[0]}, 8'h01);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            check("R10 restart active", {7'b0, pad_out[0]}, 8'h01);
        end
        @(negedge clk);
        check("R10 restart ended", {7'b0, pad_out[0]}, 8'h00);

        // R10 cancel by writing zero
        bus_write(8'h09, 8'h11);
        check("R10 cancel start", {7'b0, pad_out[0]}, 8'h01);
        bus_write(8'h09, 8'h10);
        check("R10 cancel low", {7'b0, pad_out[0]}, 8'h00);
        bus_read(8'h09, 8'h10, "R10 cancel data");

        // R12 hold while running, then reset without capture
        pad_in = 7'h2A;
        idle(3);
        bus_read(8'h0D, 8'h55, "R12 hold running");
        strap_capture_en = 1'b0;
        rst = 1'b1;
        idle(4);
        rst = 1'b0;
        idle(1);
        bus_read(8'h0D, 8'h55, "R12 hold disabled reset");
        check("R12 strap addr kept", {5'b0, strap_addr}, 8'h05);
        bus_read(8'h0B, 8'h7F, "R1 dir after second reset");
        bus_read(8'h0C, 8'h00, "R1 style after second reset");
        idle(2);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule